// File: doc/BRIEF.md
# Saturating Down Timer with Enable-Qualified Zero Flag

This block is a small clocked countdown timer. A starting value is written into its count register by a load strobe on a rising clock edge. After that, every rising edge with the count enable high takes one off the count, until the count reaches zero. At zero it stops and does not wrap around. It stays there until a new value is loaded.

The zero flag is not a plain decode of the count. It is high only while the count is zero and the count enable is high at the same time. The flag is a combinational function of the registered count and the live enable input, so it follows the enable within the same cycle. The count output comes straight from the state flip-flops. The register width is a parameter with a default of 3 bits.

Top module: `sat_down_timer`

## Requirements
- R1: A synchronous active-high reset forces the count to 0 on the rising edge. Reset takes priority over load and over counting.
- R2: When load is high at a rising edge, the count takes the load data value after that edge. When load is low, load data has no effect.
- R3: Load has priority over counting. With load and enable both high on the same edge, the count becomes the load data and is not decremented.
- R4: With load low, enable high and a non-zero count, each rising edge lowers the count by exactly one.
- R5: With load low, enable high and the count at 0, the count stays at 0 on later edges. It never wraps to the all-ones value.
- R6: With load and enable both low, the count keeps its value across rising edges.
- R7: The zero flag is 1 exactly when the count is 0 and the enable input is 1. It responds to a change of the enable in the same cycle, with no clock edge needed.
- R8: Loading 0 with the enable high gives a count of 0 and a zero flag of 1 after that edge. Later enabled edges leave both unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe, sampled on the rising edge |
| load_val_i | input | WIDTH | Starting value written by a load |
| cnt_en_i | input | 1 | Count enable; also qualifies the zero flag |
| count_o | output | WIDTH | Present count value |
| zero_o | output | 1 | High while count is 0 and enable is high |

## Verification
The count is tried with a load followed by idle cycles, then by an unbroken enabled run down to zero and beyond. This separates holding from decrementing, and saturation from wrap-around. Load and enable are driven high together with values above and below the present count, which shows whether load wins or a decrement slips in. Loading zero under enable, and toggling the enable between edges while the count is at zero, tell an enable-qualified combinational flag apart from a registered or unqualified terminal-count decode. Reset is asserted together with an active load to confirm that reset wins.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    localparam int unsigned DEF_WIDTH = 3;

    // Action chosen for the next edge. Reset is handled separately in the register.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_DEC  = 2'd2,
        ACT_PARK = 2'd3
    } sdt_act_e;

endpackage

// File: rtl/sdt_arbiter.sv
module sdt_arbiter
    import sdt_pkg::*;
(
    input  logic     load_i,
    input  logic     cnt_en_i,
    input  logic     at_zero_i,
    output sdt_act_e act_o
);

    // Load outranks counting; counting at zero parks instead of wrapping.
    always_comb begin
        if (load_i) begin
            act_o = ACT_LOAD;
        end else if (cnt_en_i && !at_zero_i) begin
            act_o = ACT_DEC;
        end else if (cnt_en_i) begin
            act_o = ACT_PARK;
        end else begin
            act_o = ACT_HOLD;
        end
    end

endmodule

// File: rtl/sdt_datapath.sv
module sdt_datapath
    import sdt_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  sdt_act_e         act_i,
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] nxt_o
);

    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO = '0;

    always_comb begin
        unique case (act_i)
            ACT_LOAD: nxt_o = load_val_i;
            ACT_DEC:  nxt_o = cur_i - ONE;
            ACT_PARK: nxt_o = ZERO;
            default:  nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/sdt_zero_flag.sv
module sdt_zero_flag (
    input  logic at_zero_i,
    input  logic cnt_en_i,
    output logic zero_o
);

    // Combinational on purpose: follows the enable in the same cycle.
    always_comb begin
        zero_o = at_zero_i & cnt_en_i;
    end

endmodule

// File: rtl/sat_down_timer.sv
module sat_down_timer
    import sdt_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             cnt_en_i,
    output logic [WIDTH-1:0] count_o,
    output logic             zero_o
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t           state_d;
    state_t           state_q;
    sdt_act_e         act;
    logic             at_zero;
    logic [WIDTH-1:0] cnt_nxt;

    assign at_zero = (state_q.cnt == '0);

    sdt_arbiter u_arb (
        .load_i    (load_i),
        .cnt_en_i  (cnt_en_i),
        .at_zero_i (at_zero),
        .act_o     (act)
    );

    sdt_datapath #(.WIDTH(WIDTH)) u_dp (
        .act_i      (act),
        .cur_i      (state_q.cnt),
        .load_val_i (load_val_i),
        .nxt_o      (cnt_nxt)
    );

    sdt_zero_flag u_zf (
        .at_zero_i (at_zero),
        .cnt_en_i  (cnt_en_i),
        .zero_o    (zero_o)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.cnt;

endmodule

// File: rtl/sat_down_timer_chk.sv
module sat_down_timer_chk #(
    parameter int unsigned WIDTH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             load_i,
    input logic [WIDTH-1:0] load_val_i,
    input logic             cnt_en_i,
    input logic [WIDTH-1:0] count_o,
    input logic             zero_o
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (count_o == '0));

    assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (count_o == $past(load_val_i)));

    assert_load_beats_count_R3: assert property (@(posedge clk) disable iff (rst)
        (load_i && cnt_en_i) |=> (count_o == $past(load_val_i)));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_en_i && count_o != '0) |=> (count_o == $past(count_o) - WIDTH'(1)));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_en_i && count_o == '0) |=> (count_o == '0));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !cnt_en_i) |=> $stable(count_o));

    assert_flag_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        zero_o |-> (cnt_en_i && count_o == '0));

    assert_flag_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_en_i && count_o == '0) |-> zero_o);

    assert_zero_load_R8: assert property (@(posedge clk) disable iff (rst)
        (load_i && cnt_en_i && load_val_i == '0) |=> (count_o == '0));

endmodule

bind sat_down_timer sat_down_timer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .cnt_en_i   (cnt_en_i),
    .count_o    (count_o),
    .zero_o     (zero_o)
);

// File: tb/sat_down_timer_bench.sv
module sat_down_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 3;
    localparam int NVEC       = 16;

    // Vector layout: {load, load_val[2:0], enable, exp_count[2:0], exp_zero}
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b1, 3'd5, 1'b0, 3'd5, 1'b0},
        {1'b0, 3'd2, 1'b0, 3'd5, 1'b0},
        {1'b0, 3'd0, 1'b1, 3'd4, 1'b0},
        {1'b0, 3'd7, 1'b1, 3'd3, 1'b0},
        {1'b0, 3'd0, 1'b1, 3'd2, 1'b0},
        {1'b0, 3'd0, 1'b1, 3'd1, 1'b0},
        {1'b0, 3'd0, 1'b1, 3'd0, 1'b1},
        {1'b0, 3'd6, 1'b1, 3'd0, 1'b1},
        {1'b0, 3'd0, 1'b0, 3'd0, 1'b0},
        {1'b1, 3'd7, 1'b1, 3'd7, 1'b0},
        {1'b1, 3'd3, 1'b1, 3'd3, 1'b0},
        {1'b0, 3'd0, 1'b1, 3'd2, 1'b0},
        {1'b0, 3'd5, 1'b0, 3'd2, 1'b0},
        {1'b1, 3'd0, 1'b1, 3'd0, 1'b1},
        {1'b0, 3'd0, 1'b1, 3'd0, 1'b1},
        {1'b1, 3'd6, 1'b0, 3'd6, 1'b0}
    };

    localparam string VTAG [NVEC] = '{
        "R2", "R6", "R4", "R4", "R4", "R4", "R7", "R5",
        "R7", "R3", "R3", "R4", "R6", "R8", "R8", "R2"
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         load_i;
    logic [W-1:0] load_val_i;
    logic         cnt_en_i;
    logic [W-1:0] count_o;
    logic         zero_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sat_down_timer #(.WIDTH(W)) u_sat_down_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .cnt_en_i   (cnt_en_i),
        .count_o    (count_o),
        .zero_o     (zero_o)
    );

    task automatic check(input string tag, input logic [W-1:0] exp_c, input logic exp_z);
        total++;
        if (count_o !== exp_c || zero_o !== exp_z) begin
            bad++;
            $display("FAIL %s: count=%0d zero=%0b expected count=%0d zero=%0b",
                     tag, count_o, zero_o, exp_c, exp_z);
        end
    endtask

    // Drive at the falling edge; one rising edge passes before the next falling edge.
    task automatic step(input logic ld, input logic [W-1:0] v, input logic en);
        load_i     = ld;
        load_val_i = v;
        cnt_en_i   = en;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        total++;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        load_i     = 1'b0;
        load_val_i = '0;
        cnt_en_i   = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state, flag follows the enable while at zero
        check("R1", 3'd0, 1'b0);
        cnt_en_i = 1'b1;
        #1;
        check("R1", 3'd0, 1'b1);
        cnt_en_i = 1'b0;
        rst      = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][8], VEC[i][7:5], VEC[i][4]);
            check(VTAG[i], VEC[i][3:1], VEC[i][0]);
        end

        // R7: the flag tracks the enable with no clock edge, at zero and away from it
        step(1'b1, 3'd0, 1'b0);
        check("R7", 3'd0, 1'b0);
        load_i   = 1'b0;
        cnt_en_i = 1'b1;
        #1;
        check("R7", 3'd0, 1'b1);
        cnt_en_i = 1'b0;
        #1;
        check("R7", 3'd0, 1'b0);
        step(1'b1, 3'd1, 1'b0);
        cnt_en_i = 1'b1;
        #1;
        check("R7", 3'd1, 1'b0);

        // R4 and R5: full run from the top value, then extra enabled edges
        step(1'b1, 3'd7, 1'b1);
        for (int k = 6; k >= 0; k--) begin
            step(1'b0, 3'd0, 1'b1);
            check("R4", k[W-1:0], (k == 0));
        end
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 3'd7, 1'b1);
            check("R5", 3'd0, 1'b1);
        end

        // R1: reset dominates a simultaneous load
        step(1'b1, 3'd4, 1'b0);
        rst = 1'b1;
        step(1'b1, 3'd6, 1'b1);
        check("R1", 3'd0, 1'b1);
        rst = 1'b0;
        step(1'b0, 3'd0, 1'b0);
        check("R1", 3'd0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule